// File: doc/BRIEF.md
# Vendor Request Register Bridge

This block sits behind a USB control-transfer parser and turns already-decoded vendor requests into accesses to a small register set for a serial port. Host-to-device requests load a baud divisor, a line control byte and a modem control byte. Device-to-host requests read back the current modem status or the stored line control byte. Every accepted request gets exactly one response. The response is a data byte for reads and a zero byte for writes. A request that is not recognised, or that has the wrong length, is answered with a stall.

The bridge also holds a transmit permission flag. Writing the baud divisor clears this flag. The flag is set again only after two auxiliary one-byte configuration requests arrive in a fixed order. Until then the transmitter may run only while CTS is asserted. The divisor is computed by the host as 115200 divided by the wanted baud rate; the bridge stores it as sent.

Independently of requests, the bridge watches the modem status and line status bytes coming from the serial engine. Whenever either byte changes, it emits a two-byte report.

Top module: `vreq_bridge`

## Requirements
- R1: After reset, the divisor, line control and modem control outputs are zero, tx_nocts_en is low, rsp_valid and rpt_valid are low, and req_ready is high.
- R2: An accepted request with type 0x40, code 5 and length 4 loads the divisor little-endian from req_data. The first byte, req_data[7:0], is the least significant byte. The divisor output shows the low 16 bits. The response is not stalled and carries data 0x00.
- R3: Type 0x40, code 7, length 1 writes req_data[7:0] into the line control byte. Type 0x40, code 10, length 1 writes req_data[7:0] into the modem control byte. Both are answered with data 0x00 and no stall.
- R4: Type 0xC0, code 2, length 1 returns msr_in as sampled in the accept cycle. Type 0xC0, code 6, length 1 returns the stored line control byte. Neither read is stalled.
- R5: Any other combination of type, code and length is answered with rsp_stall high and data 0x00. It leaves the divisor, line control, modem control and tx_nocts_en unchanged.
- R6: The response appears in the cycle after acceptance. It holds its data until rsp_ready is seen high. While it is pending, req_ready is low and no request is accepted.
- R7: A divisor write clears tx_nocts_en. tx_nocts_en rises only on an accepted type 0x40 code 12 request whose data byte is zero, and only when it directly follows a divisor write and then a type 0x40 code 11 request with a zero data byte. Any other non-stalled request in between aborts the sequence.
- R8: tx_go is high exactly when msr_in[4] (CTS) is high or tx_nocts_en is high.
- R9: One cycle after msr_in or lsr_in changes, rpt_valid is high for one cycle. rpt_data then holds the new modem status in bits 15:8 and the new line status in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_type | input | 8 | Request type byte |
| req_code | input | 8 | Request code |
| req_len | input | 16 | Data length in bytes |
| req_data | input | 32 | Data bytes, first byte in bits 7:0 |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 8 | Read data, zero for writes and stalls |
| rsp_stall | output | 1 | Request rejected |
| msr_in | input | 8 | Modem status from the serial engine, CTS in bit 4 |
| lsr_in | input | 8 | Line status from the serial engine |
| divisor | output | 16 | Baud divisor to the baud generator |
| lcr | output | 8 | Line control byte |
| mcr | output | 8 | Modem control byte |
| tx_nocts_en | output | 1 | Transmit allowed without CTS |
| tx_go | output | 1 | Transmitter permitted to send |
| rpt_valid | output | 1 | Status report strobe |
| rpt_data | output | 16 | Report: modem status high, line status low |

## Verification
The assertions assume that the request fields are meaningful only in the cycle where req_valid meets req_ready. They also assume that msr_in and lsr_in are clean synchronous values. The bench drives every input on the falling edge and raises req_valid only while req_ready is high. It holds rsp_ready high except in one directed back-pressure case, so responses never overlap. Random requests mix legal and illegal type, code and length values. Directed cases cover the in-order, out-of-order and interrupted auxiliary sequences, as well as the CTS gating and status changes.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 16;
    localparam int DIV_BYTES = 4;
    localparam int DIV_REG_W = DIV_BYTES * BYTE_W;
    localparam int DIV_OUT_W = 16;
    localparam int CTS_BIT   = 4;

    localparam logic [7:0] TYPE_WR = 8'h40;
    localparam logic [7:0] TYPE_RD = 8'hC0;

    localparam logic [7:0] CODE_RD_MSR = 8'd2;
    localparam logic [7:0] CODE_WR_DIV = 8'd5;
    localparam logic [7:0] CODE_RD_LCR = 8'd6;
    localparam logic [7:0] CODE_WR_LCR = 8'd7;
    localparam logic [7:0] CODE_WR_MCR = 8'd10;
    localparam logic [7:0] CODE_AUX_A  = 8'd11;
    localparam logic [7:0] CODE_AUX_B  = 8'd12;

    typedef enum logic [2:0] {
        CMD_STALL, CMD_DIV, CMD_LCR, CMD_MCR,
        CMD_AUX_A, CMD_AUX_B, CMD_RD_MSR, CMD_RD_LCR
    } cmd_e;

    typedef enum logic [1:0] {
        AUX_IDLE, AUX_WAIT_A, AUX_WAIT_B
    } aux_e;
endpackage

// File: rtl/vrb_decode.sv
module vrb_decode
    import vrb_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic [7:0]    req_type,
    input  logic [7:0]    req_code,
    input  logic [LW-1:0] req_len,
    output cmd_e          cmd
);
    localparam logic [LW-1:0] LEN_ONE = LW'(1);
    localparam logic [LW-1:0] LEN_DIV = LW'(DIV_BYTES);

    always_comb begin
        cmd = CMD_STALL;
        if (req_type == TYPE_WR) begin
            unique case (req_code)
                CODE_WR_DIV: if (req_len == LEN_DIV) cmd = CMD_DIV;
                CODE_WR_LCR: if (req_len == LEN_ONE) cmd = CMD_LCR;
                CODE_WR_MCR: if (req_len == LEN_ONE) cmd = CMD_MCR;
                CODE_AUX_A:  if (req_len == LEN_ONE) cmd = CMD_AUX_A;
                CODE_AUX_B:  if (req_len == LEN_ONE) cmd = CMD_AUX_B;
                default:     cmd = CMD_STALL;
            endcase
        end else if (req_type == TYPE_RD) begin
            unique case (req_code)
                CODE_RD_MSR: if (req_len == LEN_ONE) cmd = CMD_RD_MSR;
                CODE_RD_LCR: if (req_len == LEN_ONE) cmd = CMD_RD_LCR;
                default:     cmd = CMD_STALL;
            endcase
        end
    end
endmodule

// File: rtl/vrb_report.sv
module vrb_report
    import vrb_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   msr_in,
    input  logic [W-1:0]   lsr_in,
    output logic           rpt_valid,
    output logic [2*W-1:0] rpt_data
);
    typedef struct packed {
        logic [W-1:0]   msr;
        logic [W-1:0]   lsr;
        logic           vld;
        logic [2*W-1:0] dat;
    } rpt_st_t;

    rpt_st_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.msr = msr_in;
        r_d.lsr = lsr_in;
        r_d.vld = (msr_in != r_q.msr) || (lsr_in != r_q.lsr);
        if (r_d.vld) r_d.dat = {msr_in, lsr_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rpt_valid = r_q.vld;
    assign rpt_data  = r_q.dat;
endmodule

// File: rtl/vreq_bridge.sv
module vreq_bridge
    import vrb_pkg::*;
#(
    parameter int LW   = LEN_W,
    parameter int DRW  = DIV_REG_W,
    parameter int DOW  = DIV_OUT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [7:0]     req_type,
    input  logic [7:0]     req_code,
    input  logic [LW-1:0]  req_len,
    input  logic [DRW-1:0] req_data,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic [7:0]     rsp_data,
    output logic           rsp_stall,
    input  logic [7:0]     msr_in,
    input  logic [7:0]     lsr_in,
    output logic [DOW-1:0] divisor,
    output logic [7:0]     lcr,
    output logic [7:0]     mcr,
    output logic           tx_nocts_en,
    output logic           tx_go,
    output logic           rpt_valid,
    output logic [15:0]    rpt_data
);
    typedef struct packed {
        logic [DRW-1:0] div;
        logic [7:0]     lcr;
        logic [7:0]     mcr;
        logic           nocts;
        aux_e           aux;
        logic           rvld;
        logic           rstall;
        logic [7:0]     rdat;
    } reg_st_t;

    reg_st_t st_d, st_q;
    cmd_e    cmd;
    logic    accept;
    logic    aux_zero;

    vrb_decode #(.LW(LW)) u_dec (
        .req_type (req_type),
        .req_code (req_code),
        .req_len  (req_len),
        .cmd      (cmd)
    );

    vrb_report #(.W(8)) u_rpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .msr_in    (msr_in),
        .lsr_in    (lsr_in),
        .rpt_valid (rpt_valid),
        .rpt_data  (rpt_data)
    );

    assign accept   = req_valid && !st_q.rvld;
    assign aux_zero = (req_data[7:0] == 8'h00);

    always_comb begin
        st_d = st_q;
        if (st_q.rvld && rsp_ready) st_d.rvld = 1'b0;
        if (accept) begin
            st_d.rvld   = 1'b1;
            st_d.rstall = (cmd == CMD_STALL);
            st_d.rdat   = 8'h00;
            if (cmd != CMD_STALL) st_d.aux = AUX_IDLE;
            unique case (cmd)
                CMD_DIV: begin
                    st_d.div   = req_data;
                    st_d.nocts = 1'b0;
                    st_d.aux   = AUX_WAIT_A;
                end
                CMD_LCR:    st_d.lcr  = req_data[7:0];
                CMD_MCR:    st_d.mcr  = req_data[7:0];
                CMD_AUX_A:  if (st_q.aux == AUX_WAIT_A && aux_zero) st_d.aux = AUX_WAIT_B;
                CMD_AUX_B:  if (st_q.aux == AUX_WAIT_B && aux_zero) st_d.nocts = 1'b1;
                CMD_RD_MSR: st_d.rdat = msr_in;
                CMD_RD_LCR: st_d.rdat = st_q.lcr;
                default:    st_d.rstall = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready   = !st_q.rvld;
    assign rsp_valid   = st_q.rvld;
    assign rsp_data    = st_q.rdat;
    assign rsp_stall   = st_q.rstall;
    assign divisor     = st_q.div[DOW-1:0];
    assign lcr         = st_q.lcr;
    assign mcr         = st_q.mcr;
    assign tx_nocts_en = st_q.nocts;
    assign tx_go       = msr_in[CTS_BIT] || st_q.nocts;
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [7:0]  rsp_data,
    input logic        rsp_stall,
    input logic [7:0]  msr_in,
    input logic [7:0]  lsr_in,
    input logic [15:0] divisor,
    input logic [7:0]  lcr,
    input logic [7:0]  mcr,
    input logic        tx_nocts_en,
    input logic        rpt_valid,
    input logic [15:0] rpt_data
);
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_stall)));

    p_stall_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_stall) |->
            ($stable(divisor) && $stable(lcr) && $stable(mcr) && $stable(tx_nocts_en)));

    p_stall_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_stall) |-> (rsp_data == 8'h00));

    p_nocts_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_nocts_en) |-> ($rose(rsp_valid) && !rsp_stall));

    p_report_content_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_data == {$past(msr_in), $past(lsr_in)}));
endmodule

bind vreq_bridge vrb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_stall   (rsp_stall),
    .msr_in      (msr_in),
    .lsr_in      (lsr_in),
    .divisor     (divisor),
    .lcr         (lcr),
    .mcr         (mcr),
    .tx_nocts_en (tx_nocts_en),
    .rpt_valid   (rpt_valid),
    .rpt_data    (rpt_data)
);

// File: tb/tb_vreq_bridge.sv
module tb_vreq_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_type = '0;
    logic [7:0]  req_code = '0;
    logic [15:0] req_len = '0;
    logic [31:0] req_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [7:0]  rsp_data;
    logic        rsp_stall;
    logic [7:0]  msr_in = '0;
    logic [7:0]  lsr_in = '0;
    logic [15:0] divisor;
    logic [7:0]  lcr;
    logic [7:0]  mcr;
    logic        tx_nocts_en;
    logic        tx_go;
    logic        rpt_valid;
    logic [15:0] rpt_data;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] m_div = '0;
    logic [7:0]  m_lcr = '0;
    logic [7:0]  m_mcr = '0;
    logic        m_en = 1'b0;
    int          m_ph = 0;

    always #4 clk = ~clk;

    vreq_bridge dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit legal(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
        if (t == 8'h40) return (c == 5 && l == 4) || ((c == 7 || c == 10 || c == 11 || c == 12) && l == 1);
        if (t == 8'hC0) return (c == 2 || c == 6) && l == 1;
        return 1'b0;
    endfunction

    task automatic do_req(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l, input logic [31:0] d);
        bit         st;
        logic [7:0] ed;
        st = !legal(t, c, l);
        ed = 8'h00;
        if (!st && t == 8'hC0) ed = (c == 2) ? msr_in : m_lcr;
        if (!st) begin
            if (t == 8'h40 && c == 5) begin m_div = d; m_en = 1'b0; m_ph = 1; end
            else if (t == 8'h40 && c == 11 && m_ph == 1 && d[7:0] == 0) m_ph = 2;
            else if (t == 8'h40 && c == 12 && m_ph == 2 && d[7:0] == 0) begin m_ph = 0; m_en = 1'b1; end
            else m_ph = 0;
            if (t == 8'h40 && c == 7)  m_lcr = d[7:0];
            if (t == 8'h40 && c == 10) m_mcr = d[7:0];
        end
        @(negedge clk);
        req_type = t; req_code = c; req_len = l; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R6 rsp_valid", {31'd0, rsp_valid}, 1);
        check(rsp_stall == st, "R5 stall", {31'd0, rsp_stall}, {31'd0, st});
        check(rsp_data == ed, "R4 rsp_data", {24'd0, rsp_data}, {24'd0, ed});
        check(divisor == m_div[15:0], "R2 divisor", {16'd0, divisor}, {16'd0, m_div[15:0]});
        check(lcr == m_lcr && mcr == m_mcr, "R3 lcr/mcr", {16'd0, lcr, mcr}, {16'd0, m_lcr, m_mcr});
        check(tx_nocts_en == m_en, "R7 nocts", {31'd0, tx_nocts_en}, {31'd0, m_en});
        check(tx_go == (msr_in[4] | m_en), "R8 tx_go", {31'd0, tx_go}, {31'd0, msr_in[4] | m_en});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(divisor == 0 && lcr == 0 && mcr == 0, "R1 regs", {divisor, lcr, mcr}, 0);
        check(!tx_nocts_en && !rsp_valid && !rpt_valid && req_ready, "R1 flags",
              {28'd0, tx_nocts_en, rsp_valid, rpt_valid, req_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 little-endian divisor, R7 sequence
        do_req(8'h40, 5, 4, 32'hDEAD_0060);
        check(divisor == 16'h0060, "R2 low half", {16'd0, divisor}, 32'h60);
        do_req(8'h40, 11, 1, 0);
        do_req(8'h40, 12, 1, 0);
        check(tx_nocts_en == 1'b1, "R7 enabled after sequence", {31'd0, tx_nocts_en}, 1);
        // R7 out of order: 12 before 11
        do_req(8'h40, 5, 4, 32'h0000_000C);
        do_req(8'h40, 12, 1, 0);
        do_req(8'h40, 11, 1, 0);
        check(tx_nocts_en == 1'b0, "R7 out of order", {31'd0, tx_nocts_en}, 0);
        // R7 interrupted by lcr write
        do_req(8'h40, 5, 4, 32'h0000_0001);
        do_req(8'h40, 11, 1, 0);
        do_req(8'h40, 7, 1, 32'h1B);
        do_req(8'h40, 12, 1, 0);
        check(tx_nocts_en == 1'b0, "R7 interrupted", {31'd0, tx_nocts_en}, 0);
        // R7 nonzero aux data
        do_req(8'h40, 5, 4, 32'h0000_0003);
        do_req(8'h40, 11, 1, 32'h05);
        do_req(8'h40, 12, 1, 0);
        check(tx_nocts_en == 1'b0, "R7 nonzero aux", {31'd0, tx_nocts_en}, 0);
        // R5 stall keeps registers, wrong length divisor
        do_req(8'h40, 5, 1, 32'hFFFF_FFFF);
        do_req(8'hC0, 7, 1, 0);
        do_req(8'h40, 6, 1, 0);
        // R4 reads
        do_req(8'hC0, 6, 1, 0);
        @(negedge clk); msr_in = 8'hB1; lsr_in = 8'h60;
        // R9 report one cycle later
        @(negedge clk);
        check(rpt_valid == 1'b1, "R9 rpt_valid", {31'd0, rpt_valid}, 1);
        check(rpt_data == 16'hB160, "R9 rpt_data", {16'd0, rpt_data}, 32'hB160);
        @(negedge clk);
        check(rpt_valid == 1'b0, "R9 single pulse", {31'd0, rpt_valid}, 0);
        @(negedge clk); lsr_in = 8'h62;
        @(negedge clk);
        check(rpt_valid && rpt_data == 16'hB162, "R9 lsr change", {15'd0, rpt_valid, rpt_data}, 32'h1B162);
        do_req(8'hC0, 2, 1, 0);
        // R8 CTS gating
        check(tx_go == 1'b1, "R8 cts high", {31'd0, tx_go}, 1);
        @(negedge clk); msr_in = 8'h00;
        @(negedge clk);
        check(tx_go == 1'b0, "R8 cts low, disabled", {31'd0, tx_go}, 0);

        // R6 back-pressure
        @(negedge clk);
        rsp_ready = 1'b0;
        req_type = 8'h40; req_code = 10; req_len = 1; req_data = 32'h0B; req_valid = 1'b1;
        m_mcr = 8'h0B; m_ph = 0;
        @(posedge clk); @(negedge clk);
        req_data = 32'h77;
        repeat (2) @(negedge clk);
        check(rsp_valid && !req_ready, "R6 held pending", {30'd0, rsp_valid, req_ready}, 2);
        check(mcr == 8'h0B, "R6 no second accept", {24'd0, mcr}, 32'h0B);
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R6 released", {30'd0, rsp_valid, req_ready}, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  codes [9];
            logic [7:0]  t, c;
            logic [15:0] l;
            logic [31:0] d;
            int          r;
            codes = '{2, 5, 6, 7, 10, 11, 12, 3, 13};
            c = codes[$urandom % 9];
            r = $urandom % 10;
            t = (c == 2 || c == 6) ? 8'hC0 : 8'h40;
            if (r == 0) t = 8'h41;
            else if (r == 1) t = (t == 8'h40) ? 8'hC0 : 8'h40;
            l = (c == 5) ? 16'd4 : 16'd1;
            if ($urandom % 8 == 0) l = 16'($urandom % 6);
            d = $urandom;
            if ((c == 11 || c == 12) && ($urandom % 4 != 0)) d = 0;
            if ($urandom % 16 == 0) begin
                @(negedge clk); msr_in = 8'($urandom);
                @(negedge clk);
            end
            do_req(t, c, l, d);
        end
        finish_run();
    end
endmodule